// File: doc/BRIEF.md
# LED Driver Fault Qualifier

This block decides when an LED driver has a real fault. It takes comparator results that have already been digitized: current sense above 100 mV, 600 mV and 930 mV, and voltage sense above 2 V. It also takes a switching-rate tick, the LED-on status and the open-detect enable that the startup sequencer raises once its start timer has run out. It drives an active-low fault flag, an output shutdown request and a clamp enable that pulls the compensation node down.

There are three fault classes: open string or supply loss, over-current, and over-voltage. Each class has its own qualification counter, which advances on switching ticks. A fault is confirmed only when one of these counters reaches full count. All three counters are cleared at a fixed tick interval, so slow, scattered noise never adds up to a fault. The over-current and over-voltage conditions are each stretched by a retriggerable hold timer. If the condition is gone when its hold runs out, that class's counter is cleared. A short circuit skips all counting: it cuts the outputs in the same cycle and latches the fault. A confirmed fault stays latched until power-on reset.

Top module: `led_fault_guard`

## Requirements
- R1: An open event is a cycle with `open_en_i`=1, `led_on_i`=1 and `isns_gt100_i`=0. While `open_en_i`=0 the open counter is held at zero, so open events can never raise a fault.
- R2: A class counter advances by one only on a cycle with `tick_i`=1 and that class's condition active. The FULL_COUNT-th counted tick drives `fault_n_o` low from the next clock edge.
- R3: A free-running counter of `tick_i` clears all three class counters on every INTERVAL_TICKS-th tick after reset. On that tick the clear takes priority over counting.
- R4: Any cycle with `isns_gt100_i`=1 clears the open counter.
- R5: `isns_gt600_i`=1 reloads an over-current hold timer to HOLD_CYCLES clock cycles, and the timer counts down by one each cycle. Over-current is active while the input is high or the timer is non-zero. In the cycle where the timer is 1 and the input is low, the over-current counter is cleared.
- R6: `isns_gt930_i`=1 forces `shutdown_o` high in the same cycle, with no tick needed, and latches the fault at the next edge. This check is active whenever POR is released.
- R7: `clamp_en_o` equals `vsns_gt2v_i` with no delay. Over-voltage is qualified with its own counter under the same hold, count and interval rules as R5.
- R8: Once latched, the fault keeps `fault_n_o`=0 and `shutdown_o`=1 until `por_i` is asserted.
- R9: While `por_i`=1 and just after it, `fault_n_o`=1 and all counters and timers are zero. In that state `shutdown_o` follows only `isns_gt930_i`.
- R10: Each class counts separately. Counted ticks of one class never advance another class toward the full count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| por_i | input | 1 | Power-on reset, active high, asynchronous |
| tick_i | input | 1 | One-cycle strobe at the switching rate |
| led_on_i | input | 1 | LED string is being driven |
| open_en_i | input | 1 | Open detection enabled after startup |
| isns_gt100_i | input | 1 | Current sense above 100 mV |
| isns_gt600_i | input | 1 | Current sense above 600 mV |
| isns_gt930_i | input | 1 | Current sense above 930 mV (short) |
| vsns_gt2v_i | input | 1 | Voltage sense at or above 2 V |
| fault_n_o | output | 1 | Latched fault, active low |
| shutdown_o | output | 1 | Turn the drive outputs off |
| clamp_en_o | output | 1 | Enable the compensation pull-down |

## Verification
The bench targets specific corner cases.

- **Count boundary.** It counts to one below full and stops. A counter that was off by one would fault early.
- **Interval wrap.** It starts a burst of open events just before the interval wraps. A design where counting beats the clear would fault too soon.
- **Single-cycle blip.** It drops one current-sense blip into an open-event run. A design that ignores single samples would fault.
- **Hold expiry and retrigger.** It lets the over-current and over-voltage holds expire mid-count, and separately retriggers them exactly at the expiry cycle. The first catches a design that never clears; the second catches a design that clears despite the retrigger.
- **Independent classes.** It runs over-current and over-voltage together for a count that only a shared counter would reach.
- **Short circuit.** It checks the same-cycle shutdown and the release of the latch only by POR.

// File: rtl/lfg_pkg.sv
`timescale 1ns/1ps
package lfg_pkg;

    localparam int unsigned NUM_CLASS = 3;

    typedef enum logic [1:0] {
        CLS_OPEN     = 2'd0,
        CLS_OVERCUR  = 2'd1,
        CLS_OVERVOLT = 2'd2
    } fault_class_e;

    localparam int unsigned NUM_HOLD = 2;
    localparam int unsigned HOLD_OC  = 0;
    localparam int unsigned HOLD_OV  = 1;

endpackage

// File: rtl/lfg_interval.sv
`timescale 1ns/1ps
module lfg_interval #(
    parameter int unsigned INTERVAL_TICKS = 32768
) (
    input  logic clk_i,
    input  logic por_i,
    input  logic tick_i,
    output logic wrap_o
);
    localparam int unsigned IW = (INTERVAL_TICKS > 2) ? $clog2(INTERVAL_TICKS) : 1;
    localparam logic [IW-1:0] LAST_V = IW'(INTERVAL_TICKS - 1);

    typedef struct packed {
        logic [IW-1:0] cnt;
    } ivl_state_t;

    ivl_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        wrap_o  = 1'b0;
        if (tick_i) begin
            if (state_q.cnt == LAST_V) begin
                wrap_o      = 1'b1;
                state_d.cnt = '0;
            end else begin
                state_d.cnt = state_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or posedge por_i) begin
        if (por_i) state_q <= '0;
        else       state_q <= state_d;
    end

    // R3: wraps are spaced at least two ticks apart
    assert_wrap_spacing_R3: assert property (@(posedge clk_i) disable iff (por_i)
        wrap_o |=> !wrap_o);

endmodule

// File: rtl/lfg_hold.sv
`timescale 1ns/1ps
module lfg_hold #(
    parameter int unsigned HOLD_CYCLES = 2500
) (
    input  logic clk_i,
    input  logic por_i,
    input  logic cond_i,
    output logic active_o,
    output logic expire_o
);
    localparam int unsigned HW = $clog2(HOLD_CYCLES + 1);
    localparam logic [HW-1:0] LOAD_V = HW'(HOLD_CYCLES);
    localparam logic [HW-1:0] ONE_V  = HW'(1);

    typedef struct packed {
        logic [HW-1:0] timer;
    } hold_state_t;

    hold_state_t state_d, state_q;

    always_comb begin
        state_d  = state_q;
        active_o = cond_i || (state_q.timer != '0);
        expire_o = (state_q.timer == ONE_V) && !cond_i;
        if (cond_i) begin
            state_d.timer = LOAD_V;
        end else if (state_q.timer != '0) begin
            state_d.timer = state_q.timer - 1'b1;
        end
    end

    always_ff @(posedge clk_i or posedge por_i) begin
        if (por_i) state_q <= '0;
        else       state_q <= state_d;
    end

    // R5: a seen condition keeps the status in the following cycle
    assert_hold_keeps_R5: assert property (@(posedge clk_i) disable iff (por_i)
        cond_i |=> active_o);

    // R5: after expiry the status only follows the live condition
    assert_hold_expired_R5: assert property (@(posedge clk_i) disable iff (por_i)
        expire_o |=> (active_o == cond_i));

endmodule

// File: rtl/lfg_count.sv
`timescale 1ns/1ps
module lfg_count #(
    parameter int unsigned FULL_COUNT = 256
) (
    input  logic clk_i,
    input  logic por_i,
    input  logic inc_i,
    input  logic clr_i,
    output logic reach_o
);
    localparam int unsigned CW = $clog2(FULL_COUNT + 1);
    localparam logic [CW-1:0] FULL_V = CW'(FULL_COUNT);
    localparam logic [CW-1:0] PRE_V  = CW'(FULL_COUNT - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } cnt_state_t;

    cnt_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        reach_o = 1'b0;
        if (clr_i) begin
            state_d.cnt = '0;
        end else if (inc_i && (state_q.cnt != FULL_V)) begin
            state_d.cnt = state_q.cnt + 1'b1;
            reach_o     = (state_q.cnt == PRE_V);
        end
    end

    always_ff @(posedge clk_i or posedge por_i) begin
        if (por_i) state_q <= '0;
        else       state_q <= state_d;
    end

    // R2: count never passes the full value
    assert_cnt_bounded_R2: assert property (@(posedge clk_i) disable iff (por_i)
        state_q.cnt <= FULL_V);

    // R2: no tick and no clear leaves the count untouched
    assert_cnt_idle_R2: assert property (@(posedge clk_i) disable iff (por_i)
        (!inc_i && !clr_i) |=> $stable(state_q.cnt));

    // R3: a clear always empties the counter, whatever else happens
    assert_cnt_clear_R3: assert property (@(posedge clk_i) disable iff (por_i)
        clr_i |=> (state_q.cnt == '0));

endmodule

// File: rtl/led_fault_guard.sv
`timescale 1ns/1ps
module led_fault_guard
    import lfg_pkg::*;
#(
    parameter int unsigned FULL_COUNT     = 256,
    parameter int unsigned INTERVAL_TICKS = 32768,
    parameter int unsigned HOLD_CYCLES    = 2500
) (
    input  logic clk_i,
    input  logic por_i,
    input  logic tick_i,
    input  logic led_on_i,
    input  logic open_en_i,
    input  logic isns_gt100_i,
    input  logic isns_gt600_i,
    input  logic isns_gt930_i,
    input  logic vsns_gt2v_i,
    output logic fault_n_o,
    output logic shutdown_o,
    output logic clamp_en_o
);
    typedef struct packed {
        logic fault;
    } top_state_t;

    top_state_t state_d, state_q;

    logic                 ivl_wrap;
    logic [NUM_HOLD-1:0]  hold_cond;
    logic [NUM_HOLD-1:0]  hold_act;
    logic [NUM_HOLD-1:0]  hold_exp;
    logic [NUM_CLASS-1:0] cls_inc;
    logic [NUM_CLASS-1:0] cls_clr;
    logic [NUM_CLASS-1:0] cls_reach;

    lfg_interval #(.INTERVAL_TICKS(INTERVAL_TICKS)) u_interval (
        .clk_i  (clk_i),
        .por_i  (por_i),
        .tick_i (tick_i),
        .wrap_o (ivl_wrap)
    );

    always_comb begin
        hold_cond          = '0;
        hold_cond[HOLD_OC] = isns_gt600_i;
        hold_cond[HOLD_OV] = vsns_gt2v_i;
    end

    for (genvar h = 0; h < NUM_HOLD; h++) begin : g_hold
        lfg_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
            .clk_i    (clk_i),
            .por_i    (por_i),
            .cond_i   (hold_cond[h]),
            .active_o (hold_act[h]),
            .expire_o (hold_exp[h])
        );
    end

    always_comb begin
        cls_inc = '0;
        cls_clr = '0;
        cls_inc[CLS_OPEN]     = tick_i && open_en_i && led_on_i && !isns_gt100_i;
        cls_clr[CLS_OPEN]     = ivl_wrap || isns_gt100_i || !open_en_i;
        cls_inc[CLS_OVERCUR]  = tick_i && hold_act[HOLD_OC];
        cls_clr[CLS_OVERCUR]  = ivl_wrap || hold_exp[HOLD_OC];
        cls_inc[CLS_OVERVOLT] = tick_i && hold_act[HOLD_OV];
        cls_clr[CLS_OVERVOLT] = ivl_wrap || hold_exp[HOLD_OV];
    end

    for (genvar c = 0; c < NUM_CLASS; c++) begin : g_class
        lfg_count #(.FULL_COUNT(FULL_COUNT)) u_count (
            .clk_i   (clk_i),
            .por_i   (por_i),
            .inc_i   (cls_inc[c]),
            .clr_i   (cls_clr[c]),
            .reach_o (cls_reach[c])
        );
    end

    always_comb begin
        state_d       = state_q;
        state_d.fault = state_q.fault || isns_gt930_i || (|cls_reach);
        fault_n_o     = !state_q.fault;
        shutdown_o    = state_q.fault || isns_gt930_i;
        clamp_en_o    = vsns_gt2v_i;
    end

    always_ff @(posedge clk_i or posedge por_i) begin
        if (por_i) state_q <= '0;
        else       state_q <= state_d;
    end

    // R6: a short seen at an edge is reported from that edge on
    assert_short_latch_R6: assert property (@(posedge clk_i) disable iff (por_i)
        isns_gt930_i |=> !fault_n_o);

    // R8: the fault flag never releases without POR
    assert_fault_sticky_R8: assert property (@(posedge clk_i) disable iff (por_i)
        !fault_n_o |=> (!fault_n_o && shutdown_o));

    // R2: any class reaching full count confirms the fault
    assert_reach_fault_R2: assert property (@(posedge clk_i) disable iff (por_i)
        (|cls_reach) |=> !fault_n_o);

    // R3: the interval clear reaches every class counter
    assert_wrap_clears_R3: assert property (@(posedge clk_i) disable iff (por_i)
        ivl_wrap |-> (&cls_clr));

endmodule

// File: tb/led_fault_guard_bench.sv
`timescale 1ns/1ps
module led_fault_guard_bench;

    localparam int FULL = 16;
    localparam int INTV = 64;
    localparam int HOLD = 8;

    logic clk = 1'b0;
    logic por, tick, led_on, open_en, ov;
    int   lvl;
    logic gt100, gt600, gt930;
    logic fault_n, shutdown, clamp;

    int n_checks = 0;
    int n_err    = 0;

    int m_ic, m_oct, m_ovt;
    int m_cnt [3];
    bit m_fault;

    always #10 clk = ~clk;

    assign gt100 = (lvl >= 1);
    assign gt600 = (lvl >= 2);
    assign gt930 = (lvl >= 3);

    led_fault_guard #(
        .FULL_COUNT(FULL), .INTERVAL_TICKS(INTV), .HOLD_CYCLES(HOLD)
    ) u_led_fault_guard (
        .clk_i(clk), .por_i(por), .tick_i(tick), .led_on_i(led_on),
        .open_en_i(open_en), .isns_gt100_i(gt100), .isns_gt600_i(gt600),
        .isns_gt930_i(gt930), .vsns_gt2v_i(ov), .fault_n_o(fault_n),
        .shutdown_o(shutdown), .clamp_en_o(clamp)
    );

    function automatic bit exp_shutdown(input bit f, input int l);
        return f || (l >= 3);
    endfunction

    function automatic int hold_next(input int t, input bit c);
        if (c) return HOLD;
        return (t > 0) ? t - 1 : 0;
    endfunction

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    task automatic model_clear();
        m_ic = 0; m_oct = 0; m_ovt = 0; m_fault = 0;
        for (int k = 0; k < 3; k++) m_cnt[k] = 0;
    endtask

    task automatic step(input string tag);
        bit wrap, oc_c, ov_c, oc_a, ov_a, oc_x, ov_x, reach, f_n;
        bit inc [3];
        bit clr [3];
        int cn [3];
        int ic_n, oct_n, ovt_n;
        if (por) model_clear();
        @(negedge clk);
        chk(tag, "shutdown before edge", shutdown, exp_shutdown(m_fault, lvl));
        chk("R7", "clamp", clamp, ov);
        ic_n = m_ic; oct_n = m_oct; ovt_n = m_ovt; f_n = m_fault;
        for (int k = 0; k < 3; k++) cn[k] = m_cnt[k];
        if (!por) begin
            wrap = tick && (m_ic == INTV - 1);
            if (tick) ic_n = wrap ? 0 : m_ic + 1;
            oc_c = (lvl >= 2);
            ov_c = ov;
            oc_a = oc_c || (m_oct != 0);
            ov_a = ov_c || (m_ovt != 0);
            oc_x = (m_oct == 1) && !oc_c;
            ov_x = (m_ovt == 1) && !ov_c;
            oct_n = hold_next(m_oct, oc_c);
            ovt_n = hold_next(m_ovt, ov_c);
            inc[0] = tick && open_en && led_on && (lvl == 0);
            clr[0] = wrap || (lvl >= 1) || !open_en;
            inc[1] = tick && oc_a;  clr[1] = wrap || oc_x;
            inc[2] = tick && ov_a;  clr[2] = wrap || ov_x;
            reach = 0;
            for (int k = 0; k < 3; k++) begin
                if (clr[k]) cn[k] = 0;
                else if (inc[k] && m_cnt[k] < FULL) begin
                    if (m_cnt[k] == FULL - 1) reach = 1;
                    cn[k] = m_cnt[k] + 1;
                end
            end
            f_n = m_fault || (lvl >= 3) || reach;
        end
        @(posedge clk);
        #1;
        m_ic = ic_n; m_oct = oct_n; m_ovt = ovt_n; m_fault = f_n;
        for (int k = 0; k < 3; k++) m_cnt[k] = cn[k];
        chk(tag, "fault_n", fault_n, !m_fault);
        chk(tag, "shutdown", shutdown, exp_shutdown(m_fault, lvl));
    endtask

    task automatic benign();
        tick = 1'b1; led_on = 1'b1; open_en = 1'b0; ov = 1'b0; lvl = 1;
    endtask

    task automatic do_por(input string tag);
        por = 1'b1;
        step(tag);
        por = 1'b0;
    endtask

    task automatic steps(input int n, input string tag);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    initial begin
        #(20 * 150000);
        n_err++;
        $display("FAIL R9 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'd7719));
        benign();
        por = 1'b1;
        model_clear();
        #25;
        step("R9");
        por = 1'b0;
        step("R9");
        chk("R9", "fault_n after reset", fault_n, 1'b1);
        chk("R9", "shutdown after reset", shutdown, 1'b0);

        // R1: open events without the enable, then with the LED off
        do_por("R1"); benign(); lvl = 0;
        steps(40, "R1");
        open_en = 1'b1; led_on = 1'b0;
        steps(20, "R1");
        chk("R1", "no open fault when gated", fault_n, 1'b1);

        // R2: ticks every other cycle, 15 then the 16th
        do_por("R2"); benign(); open_en = 1'b1; lvl = 0;
        for (int i = 0; i < 15; i++) begin
            tick = 1'b1; step("R2");
            tick = 1'b0; step("R2");
        end
        chk("R2", "one below full", fault_n, 1'b1);
        tick = 1'b1; step("R2");
        chk("R2", "full count", fault_n, 1'b0);

        // R4: a single 100 mV sample restarts the open count
        do_por("R4"); benign(); open_en = 1'b1; lvl = 0;
        steps(12, "R4");
        lvl = 1; step("R4");
        lvl = 0; steps(15, "R4");
        chk("R4", "restarted after blip", fault_n, 1'b1);
        step("R4");
        chk("R4", "full after restart", fault_n, 1'b0);

        // R3: an open burst that straddles the interval wrap
        do_por("R3"); benign(); open_en = 1'b1; led_on = 1'b0; lvl = 0;
        steps(56, "R3");
        led_on = 1'b1;
        steps(16, "R3");
        chk("R3", "cleared by interval", fault_n, 1'b1);
        steps(8, "R3");
        chk("R3", "full after interval", fault_n, 1'b0);

        // R5: one pulse expires, then retriggered pulses qualify
        do_por("R5"); benign();
        lvl = 2; step("R5");
        lvl = 1; steps(20, "R5");
        chk("R5", "cleared at hold expiry", fault_n, 1'b1);
        for (int i = 0; i < 40; i++) begin
            lvl = (i % HOLD == 0) ? 2 : 1;
            step("R5");
        end
        chk("R5", "retriggered over-current", fault_n, 1'b0);

        // R6: short with no tick
        do_por("R6"); benign(); tick = 1'b0; lvl = 3;
        step("R6");
        chk("R6", "short latched", fault_n, 1'b0);
        lvl = 1; step("R6");
        chk("R6", "shutdown held", shutdown, 1'b1);

        // R7: over-voltage hold expiry, then sustained over-voltage
        do_por("R7"); benign();
        ov = 1'b1; step("R7");
        ov = 1'b0; steps(20, "R7");
        chk("R7", "over-voltage cleared", fault_n, 1'b1);
        ov = 1'b1; steps(16, "R7");
        chk("R7", "over-voltage full", fault_n, 1'b0);

        // R8: latch survives benign inputs, released by POR
        benign(); steps(30, "R8");
        chk("R8", "fault kept", fault_n, 1'b0);
        chk("R8", "shutdown kept", shutdown, 1'b1);
        do_por("R8"); step("R8");
        chk("R8", "fault released", fault_n, 1'b1);
        chk("R8", "shutdown released", shutdown, 1'b0);

        // R10: both hold classes count in parallel, separately
        do_por("R10"); benign(); lvl = 2; ov = 1'b1;
        steps(4, "R10");
        lvl = 1; ov = 1'b0;
        steps(14, "R10");
        chk("R10", "separate counters", fault_n, 1'b1);

        // random phase against the model
        for (int seg = 0; seg < 16; seg++) begin
            do_por("R9");
            for (int i = 0; i < 240; i++) begin
                int bias, r;
                bias = (i / 30 + seg) % 4;
                r = int'($urandom % 100);
                tick    = ($urandom % 2) == 0;
                led_on  = ($urandom % 8) != 0;
                open_en = ($urandom % 6) != 0;
                case (bias)
                    0: lvl = (r < 95) ? 0 : 1;
                    1: lvl = (r < 97) ? 1 : 2;
                    2: lvl = (r < 60) ? 2 : 1;
                    default: lvl = 1;
                endcase
                ov = (bias == 3) ? (r < 40) : (r < 2);
                if (($urandom % 1500) == 0) lvl = 3;
                step("R2");
            end
        end

        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

endmodule